// File: doc/BRIEF.md
# Hardware Trigger Gate with Single-Entry Pending Store

This block sits between an asynchronous "sample ready" style trigger line and one transfer engine. Each rising edge of the trigger asks for one transfer. The block answers each edge in one of three ways. If the engine is free, the edge starts a transfer at once. If the engine is busy and nothing is waiting, the edge is held as a pending request. If a request is already waiting, the edge is dropped and an overrun is recorded. The pending store is always enabled and cannot be configured.

The block fills the pending store in silence, so a sample can be lost without any error. To expose this case, a sticky flag records that a request was held. A second sticky flag and a saturating counter record dropped edges. Software clears both flags with one-cycle write-one-to-clear pulses. The engine reports the end of each transfer with a one-cycle done pulse. If a request is waiting when that pulse arrives, the next start is issued on the following cycle without a new edge.

Top module: `trig_hold_ctl`

## Requirements
- R1: The trigger input passes through a two-flop synchronizer, and only a 0-to-1 change counts. An input first sampled high at clock edge k gives `start_req` high in the cycle after edge k+2, when the channel is idle. A level held high gives only one trigger.
- R2: An edge that arrives while the channel is idle (`chan_state` = 2'b00) produces a start pulse and makes the channel busy (`chan_state` = 2'b01; bit 0 = busy, bit 1 = pending).
- R3: An edge that arrives while the channel is busy with nothing pending is stored (`chan_state` = 2'b11) with no start pulse, and it sets `mem_flag`.
- R4: An edge that arrives while a request is pending is discarded. It sets `ovr_flag` and adds one to `drop_cnt`. The state stays 2'b11 and no start pulse is issued.
- R5: A done pulse that arrives while a request is pending produces a start pulse in the next cycle and leaves the state at 2'b01.
- R6: A done pulse that arrives while the channel is busy with nothing pending returns the channel to idle. A done pulse that arrives while the channel is idle has no effect.
- R7: `ovr_flag` and `mem_flag` stay set until a one-cycle pulse on `clr_ovr` or `clr_mem` clears them. If a set and a clear land on the same cycle, the flag stays set.
- R8: `drop_cnt` is 8 bits wide and saturates at 255.
- R9: `start_req` is a one-cycle pulse, and each accepted request produces exactly one pulse.
- R10: After reset, the state is 2'b00 and `start_req`, both flags and `drop_cnt` are all zero.
- R11: A done pulse is applied before an edge in the same cycle. If the channel was busy with nothing pending, the edge fires at once. If a request was pending, that request fires and the edge takes its place (state 2'b11, `mem_flag` set, no overrun).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| trig_in | input | 1 | Asynchronous trigger line |
| xfer_done | input | 1 | One-cycle transfer-complete pulse from the engine |
| clr_ovr | input | 1 | Write-one-to-clear pulse for the overrun flag |
| clr_mem | input | 1 | Write-one-to-clear pulse for the memorized flag |
| start_req | output | 1 | One-cycle transfer-start pulse |
| chan_state | output | 2 | Bit 0 busy, bit 1 pending |
| ovr_flag | output | 1 | Sticky trigger-overrun flag |
| mem_flag | output | 1 | Sticky flag: a trigger was held as pending |
| drop_cnt | output | 8 | Saturating count of discarded triggers |

## Verification
The main test sends one firing edge followed by a burst of zero to five more edges while the engine is held busy, then drains the engine with done pulses. Bursts of zero, one and two edges separate the fire, memorize and trash outcomes. Longer bursts check that only one request is ever kept and that the number of drops grows with the burst length. Edges timed to land on the same cycle as a done pulse check the ordering between the two. A long run of drops pushes the counter to saturation. A held-high trigger level shows that only edges count.

// File: rtl/trig_hold_ctl.sv
module trig_hold_ctl #(
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig_in,
  input  logic             xfer_done,
  input  logic             clr_ovr,
  input  logic             clr_mem,
  output logic             start_req,
  output logic [1:0]       chan_state,
  output logic             ovr_flag,
  output logic             mem_flag,
  output logic [CNT_W-1:0] drop_cnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [SYNC_STAGES:0] sync_q;
  logic busy_q, pend_q;

  wire trig_edge = sync_q[SYNC_STAGES-1] & ~sync_q[SYNC_STAGES];

  // done is resolved before the edge
  wire fire_pend = xfer_done & busy_q & pend_q;
  wire busy_eff  = (busy_q & ~xfer_done) | fire_pend;
  wire pend_eff  = pend_q & ~xfer_done;

  wire fire_new  = trig_edge & ~busy_eff;
  wire hold_new  = trig_edge & busy_eff & ~pend_eff;
  wire trash_new = trig_edge & busy_eff & pend_eff;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q    <= '0;
      busy_q    <= 1'b0;
      pend_q    <= 1'b0;
      start_req <= 1'b0;
      ovr_flag  <= 1'b0;
      mem_flag  <= 1'b0;
      drop_cnt  <= '0;
    end else begin
      sync_q    <= {sync_q[SYNC_STAGES-1:0], trig_in};
      busy_q    <= busy_eff | fire_new;
      pend_q    <= pend_eff | hold_new;
      start_req <= fire_pend | fire_new;
      ovr_flag  <= trash_new | (ovr_flag & ~clr_ovr);
      mem_flag  <= hold_new | (mem_flag & ~clr_mem);
      if (trash_new && drop_cnt != CNT_MAX)
        drop_cnt <= drop_cnt + 1'b1;
    end
  end

  assign chan_state = {pend_q, busy_q};
endmodule

module trig_hold_ctl_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             clr_ovr,
  input logic             clr_mem,
  input logic             start_req,
  input logic [1:0]       chan_state,
  input logic             ovr_flag,
  input logic             mem_flag,
  input logic [CNT_W-1:0] drop_cnt
);
  p_pend_implies_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    chan_state != 2'b10);
  p_start_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start_req |-> chan_state[0]);
  p_mem_rise_pending_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_flag) |-> chan_state == 2'b11);
  p_ovr_counts_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr_flag) |-> (drop_cnt != $past(drop_cnt) || drop_cnt == {CNT_W{1'b1}}));
  p_ovr_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_flag && !clr_ovr) |=> ovr_flag);
  p_mem_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_flag && !clr_mem) |=> mem_flag);
  p_cnt_sat_r8: assert property (@(posedge clk) disable iff (!rst_n)
    drop_cnt == {CNT_W{1'b1}} |=> drop_cnt == {CNT_W{1'b1}});
  p_cnt_mono_r8: assert property (@(posedge clk) disable iff (!rst_n)
    drop_cnt >= $past(drop_cnt));
endmodule

bind trig_hold_ctl trig_hold_ctl_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .clr_ovr(clr_ovr), .clr_mem(clr_mem),
  .start_req(start_req), .chan_state(chan_state), .ovr_flag(ovr_flag),
  .mem_flag(mem_flag), .drop_cnt(drop_cnt)
);

// File: tb/sim_trig_hold_ctl.sv
`timescale 1ns/1ps
module sim_trig_hold_ctl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic trig_in = 1'b0, xfer_done = 1'b0, clr_ovr = 1'b0, clr_mem = 1'b0;
  logic start_req, ovr_flag, mem_flag;
  logic [1:0] chan_state;
  logic [7:0] drop_cnt;
  int total = 0, bad = 0, starts = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  trig_hold_ctl u0 (.clk, .rst_n, .trig_in, .xfer_done, .clr_ovr, .clr_mem,
    .start_req, .chan_state, .ovr_flag, .mem_flag, .drop_cnt);

  always @(negedge clk) if (rst_n && start_req) starts++;

  task automatic tick(int n); repeat (n) @(negedge clk); endtask

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic edge_trig;
    trig_in = 1'b1; tick(3); trig_in = 1'b0; tick(3);
  endtask

  task automatic done_pulse;
    xfer_done = 1'b1; tick(1); xfer_done = 1'b0; tick(1);
  endtask

  task automatic clear_all;
    clr_ovr = 1'b1; clr_mem = 1'b1; tick(1); clr_ovr = 1'b0; clr_mem = 1'b0; tick(1);
  endtask

  task automatic report;
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #800000;
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    report();
  end

  initial begin
    int s0, drops;
    tick(3);
    // R10 reset state
    chk("R10 state", chan_state, 0);
    chk("R10 start", start_req, 0);
    chk("R10 flags", {ovr_flag, mem_flag}, 0);
    chk("R10 cnt", drop_cnt, 0);
    rst_n = 1'b1; tick(2);

    // R1 latency and level insensitivity, R9 single pulse
    trig_in = 1'b1;
    tick(1); chk("R1 lat1", start_req, 0);
    tick(1); chk("R1 lat2", start_req, 0);
    tick(1); chk("R1 lat3", start_req, 1);
    chk("R2 busy", chan_state, 1);
    tick(1); chk("R9 one cycle", start_req, 0);
    tick(10);
    chk("R1 level ignored", chan_state, 1);
    chk("R1 level no mem", mem_flag, 0);
    trig_in = 1'b0; tick(3);
    done_pulse();
    chk("R6 idle", chan_state, 0);
    done_pulse();
    chk("R6 done idle no effect", chan_state, 0);
    chk("R6 done idle no start", start_req, 0);

    // sweep of burst lengths
    drops = 0;
    for (int n = 0; n <= 5; n++) begin
      s0 = starts;
      edge_trig();
      chk("R2 fire", starts - s0, 1);
      for (int j = 0; j < n; j++) edge_trig();
      chk("R3 state", chan_state, (n == 0) ? 1 : 3);
      chk("R3 mem", mem_flag, (n >= 1));
      chk("R4 ovr", ovr_flag, (n >= 2));
      drops += (n >= 2) ? n - 1 : 0;
      chk("R4 cnt", drop_cnt, drops);
      chk("R3 no extra start", starts - s0, 1);
      if (n >= 1) begin
        xfer_done = 1'b1; tick(1); xfer_done = 1'b0;
        chk("R5 start next cycle", start_req, 1);
        chk("R5 state", chan_state, 1);
        tick(1);
      end
      done_pulse();
      done_pulse();
      chk("R9 total starts", starts - s0, 1 + (n >= 1));
      chk("R6 back idle", chan_state, 0);
      chk("R7 ovr sticky", ovr_flag, (n >= 2));
      clear_all();
      chk("R7 cleared", {ovr_flag, mem_flag}, 0);
    end

    // R11 done and edge same cycle, busy no pending
    edge_trig();
    s0 = starts;
    trig_in = 1'b1; tick(2); xfer_done = 1'b1; tick(1); xfer_done = 1'b0;
    chk("R11 fire", start_req, 1);
    chk("R11 state", chan_state, 1);
    chk("R11 no mem", mem_flag, 0);
    trig_in = 1'b0; tick(3);
    // R11 pending + done + edge
    edge_trig();
    chk("R3 held", chan_state, 3);
    clear_all();
    trig_in = 1'b1; tick(2); xfer_done = 1'b1; tick(1); xfer_done = 1'b0;
    chk("R11 pend fires", start_req, 1);
    chk("R11 pend state", chan_state, 3);
    chk("R11 mem set", mem_flag, 1);
    chk("R11 no ovr", ovr_flag, 0);
    trig_in = 1'b0; tick(3);

    // R7 set wins over clear
    trig_in = 1'b1; tick(2); clr_ovr = 1'b1; tick(1); clr_ovr = 1'b0;
    chk("R7 set wins", ovr_flag, 1);
    trig_in = 1'b0; tick(3);
    drops += 1;

    // R8 saturation
    for (int j = 0; j < 260; j++) edge_trig();
    drops += 260;
    chk("R8 saturate", drop_cnt, (drops > 255) ? 255 : drops);
    chk("R4 state held", chan_state, 3);
    repeat (3) done_pulse();
    chk("R6 final idle", chan_state, 0);
    report();
  end
endmodule